// File: doc/BRIEF.md
# DMA Channel Bus Arbiter

This block sits between eight DMA channels and the single system bus they share. Each channel raises a request line when it has a unit transfer to perform. The arbiter asks the CPU-side bus owner for the bus, waits until the owner acknowledges, and then grants the bus to exactly one channel. A run-time input chooses how the winner is picked. In fixed order the lowest channel number always wins. In rotating order the search starts just after the channel served last.

A second run-time input sets how long a winner keeps the bus. In burst mode the winner keeps the bus over any number of unit transfers until it reports that its whole transfer has ended. In cycle-stealing mode the bus goes back to the owner after every unit transfer, and the channels are arbitrated again. An intermittent form of cycle-stealing also holds off the next bus request for a selectable idle gap of 16 or 64 clocks.

No data passes through the block, so it has no valid/ready stream. Every pin is a plain level control. The bus owner applies back-pressure by holding `bus_ack` low, and no grant is issued while it does so.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, `grant` is all zero and `bus_req` is low.
- R2: `grant` is one-hot or all zero. A channel is granted only if its request line was high in the cycle in which the grant was decided.
- R3: `bus_req` rises when at least one channel requests, the arbiter is idle, `bus_ack` is low and no idle gap is running. `grant` becomes non-zero only in the cycle after `bus_ack` is sampled high while `bus_req` is high.
- R4: With `prio_rr` = 0 (fixed order), the requesting channel with the lowest index wins.
- R5: With `prio_rr` = 1 (rotating order), the search starts at the channel after the last granted one and wraps from 7 to 0. The last-granted index resets to 7, so the first search starts at channel 0. The index is updated on every grant in either order.
- R6: With `bus_mode` = 2'b00 (burst), the grant stays on the same channel across unit completions (`chan_done`). Other requests do not pre-empt it. It is released only on a cycle where both `chan_done` and `chan_end` are high for the granted channel.
- R7: With `bus_mode` = 2'b01 (cycle-steal) or 2'b10 / 2'b11 (cycle-steal with gap), `grant` clears on the edge that samples `chan_done` high for the granted channel.
- R8: `bus_req` is low in the cycle right after the releasing unit completion, and the grant clears on that same edge.
- R9: With `bus_mode` = 2'b10 or 2'b11, each release starts an idle gap of 16 clocks (`gap_long` = 0) or 64 clocks (`gap_long` = 1). With a request pending and `bus_ack` low, `bus_req` rises G+2 edges after the edge that sampled the release, where G is 0 in the other modes.
- R10: `chan_done` and `chan_end` bits of channels that are not granted have no effect on `grant` or `bus_req`.
- R11: If every request drops while the bus is requested but not yet acknowledged, `bus_req` falls on the next edge and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_req | input | 8 | Per-channel transfer request |
| chan_done | input | 8 | Per-channel unit transfer complete (single-cycle pulse) |
| chan_end | input | 8 | Per-channel whole-transfer end, qualified by `chan_done` |
| prio_rr | input | 1 | 0 = fixed order, 1 = rotating order |
| bus_mode | input | 2 | 00 burst, 01 cycle-steal, 1x cycle-steal with idle gap |
| gap_long | input | 1 | Idle gap length: 0 = 16 clocks, 1 = 64 clocks |
| bus_ack | input | 1 | Bus owner has handed over the bus |
| bus_req | output | 1 | Request for the bus toward the owner |
| grant | output | 8 | One-hot channel grant |

## Verification
The bench walks a sequence of single-unit services in which the rotating pointer carries over from one entry to the next. A pointer that failed to wrap, or that updated only in one order, would grant the wrong channel in later entries. Directed tests hold `bus_ack` low after a request, which catches a design that grants too early. They also pulse completions in burst mode, both with and without an end flag and from channels that are not granted, which catches early release or pre-emption. The gap tests count the edges up to the next bus request for both gap lengths and for no gap, so an off-by-one gap counter shows up as a wrong count. A final test withdraws a request before acknowledge, which catches a design that stays stuck requesting the bus.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_REQ  = 2'd1,
    ARB_XFER = 2'd2
  } arb_state_e;

  localparam logic [1:0] MODE_BURST = 2'b00;
  localparam logic [1:0] MODE_STEAL = 2'b01;

  function automatic logic mode_has_gap(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/dmarb_prio_pick.sv
module dmarb_prio_pick #(
  parameter int NUM_CH = 8,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [CW-1:0]     last_idx,
  input  logic              rr_en,
  output logic [NUM_CH-1:0] win_oh,
  output logic [CW-1:0]     win_idx,
  output logic              any_req
);
  int base;
  int pos;

  assign any_req = |req;

  // rotating search: start one past the last winner, wrap at NUM_CH
  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    base    = 0;
    pos     = 0;
    if (rr_en) begin
      base = (int'(last_idx) >= NUM_CH - 1) ? 0 : int'(last_idx) + 1;
    end
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      pos = base + k;
      if (pos >= NUM_CH) pos = pos - NUM_CH;
      if (req[pos]) begin
        win_oh      = '0;
        win_oh[pos] = 1'b1;
        win_idx     = CW'(pos);
      end
    end
  end
endmodule

// File: rtl/dmarb_gap_timer.sv
module dmarb_gap_timer #(
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64,
  localparam int GW = $clog2(GAP_LONG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic busy
);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= long_sel ? GW'(GAP_LONG) : GW'(GAP_SHORT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dmarb_bus_ctrl.sv
module dmarb_bus_ctrl
  import dmarb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_req,
  input  logic [NUM_CH-1:0] win_oh,
  input  logic [CW-1:0]     win_idx,
  input  logic [NUM_CH-1:0] chan_done,
  input  logic [NUM_CH-1:0] chan_end,
  input  logic [1:0]        bus_mode,
  input  logic              bus_ack,
  input  logic              gap_busy,
  output logic              gap_load,
  output logic [CW-1:0]     last_idx,
  output logic [NUM_CH-1:0] grant,
  output logic              bus_req
);
  arb_state_e        state_q;
  logic [NUM_CH-1:0] grant_q;
  logic [CW-1:0]     last_q;
  logic              own_done;
  logic              own_end;
  logic              release_now;

  assign own_done    = |(grant_q & chan_done);
  assign own_end     = |(grant_q & chan_end);
  assign release_now = (state_q == ARB_XFER) && own_done &&
                       ((bus_mode != MODE_BURST) || own_end);
  assign gap_load    = release_now && mode_has_gap(bus_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
      last_q  <= CW'(NUM_CH - 1);
    end else begin
      unique case (state_q)
        ARB_IDLE: begin
          if (any_req && !bus_ack && !gap_busy) state_q <= ARB_REQ;
        end
        ARB_REQ: begin
          if (!any_req) begin
            state_q <= ARB_IDLE;
          end else if (bus_ack) begin
            state_q <= ARB_XFER;
            grant_q <= win_oh;
            last_q  <= win_idx;
          end
        end
        ARB_XFER: begin
          if (release_now) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
          end
        end
        default: begin
          state_q <= ARB_IDLE;
          grant_q <= '0;
        end
      endcase
    end
  end

  assign grant    = grant_q;
  assign last_idx = last_q;
  assign bus_req  = (state_q != ARB_IDLE);
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NUM_CH    = 8,
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_req,
  input  logic [NUM_CH-1:0] chan_done,
  input  logic [NUM_CH-1:0] chan_end,
  input  logic              prio_rr,
  input  logic [1:0]        bus_mode,
  input  logic              gap_long,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic [NUM_CH-1:0] grant
);
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] win_oh;
  logic [CW-1:0]     win_idx;
  logic [CW-1:0]     last_idx;
  logic              any_req;
  logic              gap_load;
  logic              gap_busy;

  dmarb_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req      (chan_req),
    .last_idx (last_idx),
    .rr_en    (prio_rr),
    .win_oh   (win_oh),
    .win_idx  (win_idx),
    .any_req  (any_req)
  );

  dmarb_gap_timer #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .long_sel (gap_long),
    .busy     (gap_busy)
  );

  dmarb_bus_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req   (any_req),
    .win_oh    (win_oh),
    .win_idx   (win_idx),
    .chan_done (chan_done),
    .chan_end  (chan_end),
    .bus_mode  (bus_mode),
    .bus_ack   (bus_ack),
    .gap_busy  (gap_busy),
    .gap_load  (gap_load),
    .last_idx  (last_idx),
    .grant     (grant),
    .bus_req   (bus_req)
  );
endmodule

// File: rtl/dmarb_checker.sv
module dmarb_checker #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_req,
  input logic [NUM_CH-1:0] chan_done,
  input logic [NUM_CH-1:0] chan_end,
  input logic              prio_rr,
  input logic [1:0]        bus_mode,
  input logic              gap_long,
  input logic              bus_ack,
  input logic              bus_req,
  input logic [NUM_CH-1:0] grant
);
  logic own_done;
  logic own_end;
  assign own_done = |(grant & chan_done);
  assign own_end  = |(grant & chan_end);

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grant) |-> |($past(chan_req) & grant));

  p_grant_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grant) |-> ($past(bus_ack) && $past(bus_req)));

  p_grant_needs_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> bus_req);

  p_burst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_mode == 2'b00) && own_done && !own_end) |=> (grant == $past(grant)));

  p_steal_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_mode != 2'b00) && own_done) |=> (grant == '0));

  p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_done && ((bus_mode != 2'b00) || own_end)) |=> !bus_req);

  p_foreign_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && !own_done) |=> (grant == $past(grant)));
endmodule

bind dma_chan_arbiter dmarb_checker #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/dma_chan_arbiter_tb_top.sv
module dma_chan_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] chan_req = '0;
  logic [7:0] chan_done = '0;
  logic [7:0] chan_end = '0;
  logic       prio_rr = 1'b0;
  logic [1:0] bus_mode = 2'b01;
  logic       gap_long = 1'b0;
  logic       bus_ack = 1'b0;
  logic       bus_req;
  logic [7:0] grant;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_chan_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_done(chan_done),
    .chan_end(chan_end), .prio_rr(prio_rr), .bus_mode(bus_mode),
    .gap_long(gap_long), .bus_ack(bus_ack), .bus_req(bus_req), .grant(grant)
  );

  // fields: rotating order, request mask, expected grant
  localparam logic [16:0] VEC [12] = '{
    {1'b0, 8'hA0, 8'h20},  // R4 lowest of 5,7
    {1'b0, 8'hFF, 8'h01},  // R4 all request
    {1'b0, 8'h80, 8'h80},  // R4 lone top channel
    {1'b0, 8'h06, 8'h02},  // R4 last = 1
    {1'b1, 8'hFF, 8'h04},  // R5 start after 1
    {1'b1, 8'hFF, 8'h08},  // R5 start after 2
    {1'b1, 8'h09, 8'h01},  // R5 wrap past 7 to 0
    {1'b1, 8'h09, 8'h08},  // R5 start after 0
    {1'b1, 8'h80, 8'h80},  // R5 lone 7
    {1'b1, 8'h81, 8'h01},  // R5 wrap from 7
    {1'b1, 8'h01, 8'h01},  // R5 sole requester again
    {1'b0, 8'hC0, 8'h40}   // R4 back to fixed
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_bus_req(input string tag);
    int k = 0;
    while (!bus_req && k < 200) begin @(negedge clk); k++; end
    check(tag, {31'd0, bus_req}, 32'd1);
  endtask

  task automatic wait_grant(input string tag);
    int k = 0;
    while (grant == '0 && k < 200) begin @(negedge clk); k++; end
  endtask

  task automatic serve(input logic rr, input logic [7:0] req, input logic [7:0] exp, input string tag);
    prio_rr  = rr;
    chan_req = req;
    @(negedge clk);
    wait_bus_req({tag, " bus_req R3"});
    bus_ack = 1'b1;
    @(negedge clk);
    wait_grant(tag);
    check(tag, {24'd0, grant}, {24'd0, exp});
    chan_done = grant;
    @(negedge clk);
    chan_done = '0;
    check({tag, " release R7"}, {24'd0, grant}, 32'd0);
    check({tag, " drop R8"}, {31'd0, bus_req}, 32'd0);
    bus_ack  = 1'b0;
    chan_req = '0;
    @(negedge clk);
  endtask

  // release with done, then count edges until the next bus request
  task automatic gap_run(input logic [1:0] mode, input logic lng, input int exp_k, input string tag);
    int k = 0;
    bus_mode = mode;
    gap_long = lng;
    chan_req = 8'h10;
    @(negedge clk);
    wait_bus_req({tag, " setup R3"});
    bus_ack = 1'b1;
    @(negedge clk);
    wait_grant(tag);
    chan_done = grant;
    bus_ack   = 1'b0;
    do begin
      @(negedge clk);
      chan_done = '0;
      k++;
    end while (!bus_req && k < 200);
    check(tag, k, exp_k);
    bus_ack = 1'b1;
    @(negedge clk);
    wait_grant(tag);
    chan_done = grant;
    chan_req  = '0;
    bus_ack   = 1'b0;
    @(negedge clk);
    chan_done = '0;
    repeat (70) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 grant at reset", {24'd0, grant}, 32'd0);
    check("R1 bus_req at reset", {31'd0, bus_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    bus_mode = 2'b01;
    for (int i = 0; i < 12; i++) begin
      serve(VEC[i][16], VEC[i][15:8], VEC[i][7:0], $sformatf("vec%0d R2 R4 R5", i));
    end

    // R3 no grant while bus_ack held low
    prio_rr  = 1'b0;
    bus_mode = 2'b00;
    chan_req = 8'h06;
    @(negedge clk);
    wait_bus_req("R3 request");
    repeat (5) @(negedge clk);
    check("R3 no grant without ack", {24'd0, grant}, 32'd0);
    bus_ack = 1'b1;
    @(negedge clk);
    check("R3 grant after ack", {24'd0, grant}, 32'h02);

    // R6 burst hold, higher channel joins
    chan_req = 8'h07;
    for (int i = 0; i < 3; i++) begin
      chan_done = 8'h02;
      @(negedge clk);
      chan_done = '0;
      check("R6 burst keeps grant", {24'd0, grant}, 32'h02);
      check("R6 burst keeps bus", {31'd0, bus_req}, 32'd1);
    end
    // R10 foreign completion with end
    chan_done = 8'h81;
    chan_end  = 8'h81;
    @(negedge clk);
    chan_done = '0;
    chan_end  = '0;
    check("R10 foreign done ignored", {24'd0, grant}, 32'h02);
    check("R10 bus kept", {31'd0, bus_req}, 32'd1);
    // R6 release with end
    chan_done = 8'h02;
    chan_end  = 8'h02;
    @(negedge clk);
    chan_done = '0;
    chan_end  = '0;
    check("R6 end releases", {24'd0, grant}, 32'd0);
    check("R8 bus_req drops", {31'd0, bus_req}, 32'd0);
    chan_req = '0;
    bus_ack  = 1'b0;
    repeat (3) @(negedge clk);

    // R9 gap lengths
    gap_run(2'b01, 1'b0, 2,  "R9 no gap");
    gap_run(2'b10, 1'b0, 18, "R9 short gap");
    gap_run(2'b10, 1'b1, 66, "R9 long gap");

    // R11 withdraw before ack
    bus_mode = 2'b01;
    chan_req = 8'h10;
    @(negedge clk);
    wait_bus_req("R11 request");
    chan_req = '0;
    @(negedge clk);
    check("R11 bus_req falls", {31'd0, bus_req}, 32'd0);
    bus_ack = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 no grant", {24'd0, grant}, 32'd0);
    bus_ack = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule